// File: doc/BRIEF.md
# Management Memory Region Decoder

This block sits beside a processor bus interface and picks, for every memory cycle, which of two address strobes goes out. One strobe selects ordinary system memory. The other selects a private management memory used while the processor runs its management handler. The decision depends on five things:

- where the address falls relative to a programmable region;
- whether the cycle is an instruction fetch, a data read, a data write or a cache write-back;
- whether the processor is currently in management mode;
- two access-control bits. One lets normal-mode code reach the region. The other lets management-mode data reach ordinary memory that lies under the region.

The region is given by a page-granular base and a 4-bit size code. The sizes are powers of two from 4 KB to 32 MB. There is one code that turns the region off and one code that is an alias of the smallest size. The block also raises a flag telling the address path to ignore the A20 mask, and a region-hit flag for the bus logic.

The cycle inputs are captured on a clock edge. The strobes and flags appear on the registered outputs one cycle later, so the decode fits in front of a bus state machine that launches the strobe in the following cycle.

Top module: `mmrDecoder`

## Requirements
- R1: Size code 0 turns the region off, so no address hits. Code n in 1..14 selects a region of 4096·2^(n-1) bytes. Code 15 selects 4096 bytes, the same as code 1.
- R2: An address hits when its bits 31..12, with the low (n-1) bits of that page number masked off, equal the base page masked the same way. A base that is not aligned to the region size is therefore truncated down to the region boundary.
- R3: In management mode with the main-access bit clear, every valid cycle except a write-back uses the management strobe, whether it hits or misses.
- R4: In management mode with the main-access bit set, a fetch that hits uses the management strobe. A data read or write that hits uses the normal strobe. Any miss uses the normal strobe.
- R5: In normal mode with the management-access bit set and the main-access bit clear, fetches and data cycles that hit use the management strobe, and misses use the normal strobe. With the management-access bit clear, every normal-mode cycle uses the normal strobe.
- R6: In normal mode with both bits set, the main-access bit takes precedence. Data hits use the normal strobe, and fetch hits still use the management strobe.
- R7: A write-back cycle (type 3) always uses the normal strobe, even when it hits the region. The cycle types are 0 fetch, 1 data read, 2 data write, 3 write-back.
- R8: The A20-bypass output is high exactly in the cycles where the management strobe is high.
- R9: Each valid cycle gives exactly one strobe. An invalid cycle gives no strobe, no region hit and no A20 bypass.
- R10: Outputs are registered. They reflect the inputs sampled at the previous rising edge. While reset is active, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycValid | input | 1 | A memory cycle is presented this clock |
| cycAddr | input | 32 | Byte address of the cycle |
| cycType | input | 2 | 0 fetch, 1 data read, 2 data write, 3 write-back |
| inMgmt | input | 1 | Processor is in management mode |
| regionBase | input | 20 | Region base, address bits 31..12 |
| regionSize | input | 4 | Region size code |
| mgmtAccessEn | input | 1 | Normal-mode cycles that hit the region go to management memory |
| mainAccessEn | input | 1 | Management-mode data cycles that hit the region go to ordinary memory |
| normStrobe | output | 1 | Normal-memory strobe |
| mgmtStrobe | output | 1 | Management-memory strobe |
| regionHit | output | 1 | Valid cycle whose address fell in the region |
| a20Bypass | output | 1 | Ignore the A20 mask for this cycle |

## Verification
The assertions check the following on every cycle:

- one-hot strobe selection for valid cycles and silence for invalid ones;
- write-backs never take the management strobe;
- a disabled region never hits;
- A20 bypass tracks the management strobe;
- a fetch that hits in management mode always takes the management strobe;
- normal mode without the access bit never selects management memory.

The region arithmetic cannot be judged from the ports alone. This covers the size decode, the alias code, base truncation and the exact region boundaries. The bench shows these with its sweep over every size code, addresses at and just beyond both region edges, every mode and bit combination, and every cycle type.

// File: rtl/mmrDecoderPkg.sv
package mmrDecoderPkg;

  localparam int ADDR_W     = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int PAGE_W     = ADDR_W - PAGE_SHIFT;
  localparam int SIZE_W     = 4;
  localparam int TYPE_W     = 2;

  typedef enum logic [TYPE_W-1:0] {
    CYC_FETCH = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_WBACK = 2'd3
  } cycType_e;

  // Control-to-datapath selection for one cycle.
  typedef struct packed {
    logic selNorm;
    logic selMgmt;
    logic hitQual;
  } steer_t;

endpackage

// File: rtl/mmrRegionPath.sv
module mmrRegionPath
  import mmrDecoderPkg::*;
#(
  parameter int P_ADDR_W     = ADDR_W,
  parameter int P_PAGE_SHIFT = PAGE_SHIFT,
  parameter int P_SIZE_W     = SIZE_W
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [P_ADDR_W-1:0]            cycAddr,
  input  logic [P_ADDR_W-P_PAGE_SHIFT-1:0] regionBase,
  input  logic [P_SIZE_W-1:0]            regionSize,
  output logic                           rawHit,
  input  steer_t                         steer,
  output logic                           normStrobe,
  output logic                           mgmtStrobe,
  output logic                           regionHit,
  output logic                           a20Bypass
);

  localparam int PW         = P_ADDR_W - P_PAGE_SHIFT;
  localparam int ALIAS_CODE = (1 << P_SIZE_W) - 1;

  logic [PW-1:0]       addrPage;
  logic [P_SIZE_W-1:0] spanLog;
  logic                regionOn;
  logic [PW-1:0]       keepBit;
  logic [PW-1:0]       diffBits;

  assign addrPage = cycAddr[P_ADDR_W-1:P_PAGE_SHIFT];
  assign regionOn = (regionSize != '0);

  // Number of page-number bits that lie inside the region.
  always_comb begin
    if (regionSize == P_SIZE_W'(ALIAS_CODE) || regionSize == '0)
      spanLog = '0;
    else
      spanLog = regionSize - P_SIZE_W'(1);
  end

  genvar gi;
  generate
    for (gi = 0; gi < PW; gi++) begin : g_mask
      assign keepBit[gi]  = (32'(spanLog) <= gi);
      assign diffBits[gi] = keepBit[gi] & (addrPage[gi] ^ regionBase[gi]);
    end
  endgenerate

  assign rawHit = regionOn && (diffBits == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      normStrobe <= 1'b0;
      mgmtStrobe <= 1'b0;
      regionHit  <= 1'b0;
      a20Bypass  <= 1'b0;
    end else begin
      normStrobe <= steer.selNorm;
      mgmtStrobe <= steer.selMgmt;
      regionHit  <= steer.hitQual;
      a20Bypass  <= steer.selMgmt;
    end
  end

endmodule

// File: rtl/mmrSteerCtl.sv
module mmrSteerCtl
  import mmrDecoderPkg::*;
(
  input  logic            cycValid,
  input  logic [TYPE_W-1:0] cycType,
  input  logic            inMgmt,
  input  logic            mgmtAccessEn,
  input  logic            mainAccessEn,
  input  logic            rawHit,
  output steer_t          steer
);

  cycType_e kind;
  logic     isFetch;
  logic     isWback;
  logic     wantMgmt;

  assign kind    = cycType_e'(cycType);
  assign isFetch = (kind == CYC_FETCH);
  assign isWback = (kind == CYC_WBACK);

  always_comb begin
    wantMgmt = 1'b0;
    if (isWback) begin
      wantMgmt = 1'b0;
    end else if (inMgmt) begin
      if (!mainAccessEn) wantMgmt = 1'b1;
      else               wantMgmt = isFetch && rawHit;
    end else if (mgmtAccessEn && rawHit) begin
      // main-access bit wins over the management-access bit for data
      wantMgmt = isFetch || !mainAccessEn;
    end
  end

  always_comb begin
    steer.selMgmt = cycValid && wantMgmt;
    steer.selNorm = cycValid && !wantMgmt;
    steer.hitQual = cycValid && rawHit;
  end

endmodule

// File: rtl/mmrDecoder.sv
module mmrDecoder
  import mmrDecoderPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cycValid,
  input  logic [31:0] cycAddr,
  input  logic [1:0]  cycType,
  input  logic        inMgmt,
  input  logic [19:0] regionBase,
  input  logic [3:0]  regionSize,
  input  logic        mgmtAccessEn,
  input  logic        mainAccessEn,
  output logic        normStrobe,
  output logic        mgmtStrobe,
  output logic        regionHit,
  output logic        a20Bypass
);

  logic   rawHit;
  steer_t steer;

  mmrRegionPath #(
    .P_ADDR_W(ADDR_W), .P_PAGE_SHIFT(PAGE_SHIFT), .P_SIZE_W(SIZE_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .cycAddr(cycAddr), .regionBase(regionBase),
    .regionSize(regionSize), .rawHit(rawHit), .steer(steer),
    .normStrobe(normStrobe), .mgmtStrobe(mgmtStrobe),
    .regionHit(regionHit), .a20Bypass(a20Bypass)
  );

  mmrSteerCtl u_ctl (
    .cycValid(cycValid), .cycType(cycType), .inMgmt(inMgmt),
    .mgmtAccessEn(mgmtAccessEn), .mainAccessEn(mainAccessEn),
    .rawHit(rawHit), .steer(steer)
  );

endmodule

// File: rtl/mmrDecoder_chk.sv
module mmrDecoder_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cycValid,
  input logic [1:0]  cycType,
  input logic        inMgmt,
  input logic [3:0]  regionSize,
  input logic        mgmtAccessEn,
  input logic        mainAccessEn,
  input logic        normStrobe,
  input logic        mgmtStrobe,
  input logic        regionHit,
  input logic        a20Bypass
);

  // Sampled copies of the cycle inputs, aligned with the registered outputs.
  logic       validQ, inMgmtQ, smacQ, mmacQ;
  logic [1:0] typeQ;
  logic [3:0] sizeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0; inMgmtQ <= 1'b0; smacQ <= 1'b0; mmacQ <= 1'b0;
      typeQ  <= 2'd0; sizeQ   <= 4'd0;
    end else begin
      validQ <= cycValid; inMgmtQ <= inMgmt; smacQ <= mgmtAccessEn;
      mmacQ  <= mainAccessEn; typeQ <= cycType; sizeQ <= regionSize;
    end
  end

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> ($countones({normStrobe, mgmtStrobe}) == 1));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !validQ |-> (!normStrobe && !mgmtStrobe && !regionHit && !a20Bypass));

  a_r7_wback_normal: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && typeQ == 2'd3) |-> (normStrobe && !mgmtStrobe));

  a_r1_off_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    (sizeQ == 4'd0) |-> !regionHit);

  a_r8_a20_follow: assert property (@(posedge clk) disable iff (!rstN)
    a20Bypass == mgmtStrobe);

  a_r4_fetch_hit_mgmt: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && inMgmtQ && typeQ == 2'd0 && regionHit) |-> mgmtStrobe);

  a_r5_normal_closed: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !inMgmtQ && !smacQ) |-> !mgmtStrobe);

  a_r3_mgmt_all: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && inMgmtQ && !mmacQ && typeQ != 2'd3) |-> mgmtStrobe);

endmodule

bind mmrDecoder mmrDecoder_chk u_chk (
  .clk(clk), .rstN(rstN), .cycValid(cycValid), .cycType(cycType),
  .inMgmt(inMgmt), .regionSize(regionSize), .mgmtAccessEn(mgmtAccessEn),
  .mainAccessEn(mainAccessEn), .normStrobe(normStrobe),
  .mgmtStrobe(mgmtStrobe), .regionHit(regionHit), .a20Bypass(a20Bypass)
);

// File: tb/mmrDecoder_tb.sv
module mmrDecoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycValid = 1'b0;
  logic [31:0] cycAddr = '0;
  logic [1:0]  cycType = '0;
  logic        inMgmt = 1'b0;
  logic [19:0] regionBase = '0;
  logic [3:0]  regionSize = '0;
  logic        mgmtAccessEn = 1'b0;
  logic        mainAccessEn = 1'b0;
  logic        normStrobe, mgmtStrobe, regionHit, a20Bypass;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mmrDecoder u_dut (
    .clk(clk), .rstN(rstN), .cycValid(cycValid), .cycAddr(cycAddr),
    .cycType(cycType), .inMgmt(inMgmt), .regionBase(regionBase),
    .regionSize(regionSize), .mgmtAccessEn(mgmtAccessEn),
    .mainAccessEn(mainAccessEn), .normStrobe(normStrobe),
    .mgmtStrobe(mgmtStrobe), .regionHit(regionHit), .a20Bypass(a20Bypass)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic longint spanOf(input int sz);
    if (sz == 0 || sz == 15) return 64'd4096;
    return 64'd4096 << (sz - 1);
  endfunction

  function automatic bit expHit(input int sz, input longint addr, input longint baseAddr);
    longint span;
    if (sz == 0) return 1'b0;
    span = spanOf(sz);
    return (addr / span) == (baseAddr / span);
  endfunction

  function automatic bit expMgmt(input bit v, input int ty, input bit inM,
                                 input bit smac, input bit mmac, input bit hit);
    if (!v || ty == 3) return 1'b0;
    if (inM) return !mmac || (ty == 0 && hit);
    return smac && hit && (ty == 0 || !mmac);
  endfunction

  function automatic string reqOf(input int ty, input bit inM, input bit smac, input bit mmac);
    if (ty == 3) return "R7";
    if (inM) return mmac ? "R4" : "R3";
    if (smac && mmac) return "R6";
    return "R5";
  endfunction

  // Drive one cycle at a falling edge, check it one falling edge later (R10).
  task automatic runCycle(input bit v, input longint addr, input int ty, input bit inM,
                          input bit smac, input bit mmac, input int sz, input longint baseAddr);
    bit h, m;
    string rq;
    cycValid = v; cycAddr = addr[31:0]; cycType = ty[1:0]; inMgmt = inM;
    mgmtAccessEn = smac; mainAccessEn = mmac; regionSize = sz[3:0];
    regionBase = baseAddr[31:12];
    @(negedge clk);
    h  = v && expHit(sz, addr, baseAddr);
    m  = expMgmt(v, ty, inM, smac, mmac, expHit(sz, addr, baseAddr));
    rq = v ? reqOf(ty, inM, smac, mmac) : "R9";
    check(sz == 0 ? "R1" : "R2", "regionHit", regionHit, h);
    check(rq, "mgmtStrobe", mgmtStrobe, m);
    check(v ? "R9" : "R9_idle", "normStrobe", normStrobe, v && !m);
    check("R8", "a20Bypass", a20Bypass, m);
  endtask

  initial begin
    longint baseAddr;
    baseAddr = 64'h1234_5000;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "normStrobe reset", normStrobe, 1'b0);
    check("R10", "mgmtStrobe reset", mgmtStrobe, 1'b0);
    check("R10", "regionHit reset", regionHit, 1'b0);
    check("R10", "a20Bypass reset", a20Bypass, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    for (int sz = 0; sz < 16; sz++) begin
      longint span, start;
      longint addrs[6];
      span  = spanOf(sz);
      start = (baseAddr / span) * span;
      addrs[0] = start;
      addrs[1] = (start + span - 1) & 64'hFFFF_FFFF;
      addrs[2] = (start - 1) & 64'hFFFF_FFFF;
      addrs[3] = (start + span) & 64'hFFFF_FFFF;
      addrs[4] = baseAddr;
      addrs[5] = 64'hFFFF_F000;
      for (int ai = 0; ai < 6; ai++)
        for (int md = 0; md < 8; md++)
          for (int ty = 0; ty < 4; ty++)
            runCycle(1'b1, addrs[ai], ty, md[2], md[1], md[0], sz, baseAddr);
    end

    // R9: invalid cycles on would-be hits in every mode
    for (int md = 0; md < 8; md++)
      runCycle(1'b0, baseAddr, 0, md[2], md[1], md[0], 3, baseAddr);

    // R10: mid-run reset clears the outputs
    cycValid = 1'b1; cycType = 2'd0; inMgmt = 1'b1; mainAccessEn = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R10", "mgmtStrobe in reset", mgmtStrobe, 1'b0);
    check("R10", "normStrobe in reset", normStrobe, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule